// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps the shadow copies of the address-register-7 stack pointer for user, master (supervisor) and interrupt state. It also holds the live A7 that the execution core reads and writes. The block watches the supervisor bit (bit 13) and the master bit (bit 12) of the status register, plus a one-bit "supervisor stack enable" flag in cache control. When either register is written, the block first parks the live A7 in the slot that was active. It then loads A7 from the slot that the new state selects. The whole swap takes one clock.

Privileged control-register moves reach the individual slots through a small request port. The port decodes which slot is named, rejects slots that the configuration does not provide, and lets software read or replace a stack pointer even while a different one is live.

Two parameters set the variant. `HAS_MASTER` enables the split between the master stack and the interrupt stack. `ALT_MODE` selects a two-slot scheme, in which the cache-control flag gates the supervisor stack.

Top module: `sp_bank`

## Requirements
- R1: After reset, the status register reads 16'h2000 (S set, M clear), A7 and all slots read zero, and the active slot is the one that this state selects. With the default configuration that is slot 2; without the master split it is slot 1; in alternate mode it is slot 0.
- R2: A status-register write or a cache-control write performs a swap at the next clock edge. The outgoing slot receives the live A7, or `a7_wdata` if `a7_wr` is high in the same cycle. A7 then takes the new slot's value. If the selected slot does not change, A7 keeps its (possibly just written) value.
- R3: In full mode (`ALT_MODE`=0), S clear selects the user slot (code 0).
- R4: In full mode with `HAS_MASTER`=1 and S set, M set selects the master slot (code 1) and M clear selects the interrupt slot (code 2).
- R5: In full mode with `HAS_MASTER`=0 and S set, slot 1 is selected whatever M holds.
- R6: In alternate mode, slot 1 is selected only when both S and the cache-control flag are set; every other combination selects slot 0.
- R7: A status-register write stores `sr_wdata & 16'hFFE0`, which is visible on `sr_q` after the edge.
- R8: Control-register slot codes are 0 = user, 1 = master, 2 = interrupt and 3 = reserved. Code 0 is always legal. Codes 1 and 2 are legal only when `HAS_MASTER`=1 and `ALT_MODE`=0. Code 3 is never legal. An illegal request raises `ctl_illegal` in the same cycle, returns zero data, and its write changes nothing.
- R9: A legal control-register write updates the named slot at the next edge, even while another slot is active. If the named slot is active, A7 takes the value, and this write wins over an `a7_wr` in the same cycle.
- R10: A legal control-register read returns the live A7 when the named slot is active, and the stored copy otherwise.
- R11: `a7_wr` alone loads `a7_wdata` into A7 at the next edge; with no write of any kind, A7 holds.
- R12: A control-register request never arrives in the same cycle as a status-register or cache-control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr | input | 1 | Status-register write strobe |
| sr_wdata | input | 16 | Status-register write value |
| sr_q | output | 16 | Stored status register system bits |
| cacr_wr | input | 1 | Cache-control write strobe |
| cacr_eusp | input | 1 | Supervisor stack enable flag carried by the cache-control write |
| a7_wr | input | 1 | Core write of the live A7 |
| a7_wdata | input | DW | Core A7 write value |
| a7 | output | DW | Live A7 |
| ctl_req | input | 1 | Control-register slot access request |
| ctl_write | input | 1 | 1 = write, 0 = read |
| ctl_sel | input | 2 | Slot code (0 user, 1 master, 2 interrupt, 3 reserved) |
| ctl_wdata | input | DW | Control-register write value |
| ctl_rdata | output | DW | Control-register read value |
| ctl_illegal | output | 1 | Request names a slot absent in this configuration |
| active_slot | output | 2 | Code of the slot that A7 currently stands for |

## Verification
A core write of A7 can land in the same cycle as a stack swap, and a control-register write to the active slot can land in the same cycle as a core A7 write. The bench sweeps every S, M and flag combination with `a7_wr` raised on half of the swaps. It checks that the written value ends up in the outgoing slot and not in the new A7. It also pairs user-slot control writes with a simultaneous A7 write, and judges from A7 and from the readback of every slot whether the control write won when the user slot was active, and whether both writes took effect when it was not.

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DW         = 32,
  parameter int HAS_MASTER = 1,
  parameter int ALT_MODE   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_wr,
  input  logic [15:0]   sr_wdata,
  output logic [15:0]   sr_q,
  input  logic          cacr_wr,
  input  logic          cacr_eusp,
  input  logic          a7_wr,
  input  logic [DW-1:0] a7_wdata,
  output logic [DW-1:0] a7,
  input  logic          ctl_req,
  input  logic          ctl_write,
  input  logic [1:0]    ctl_sel,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_rdata,
  output logic          ctl_illegal,
  output logic [1:0]    active_slot
);
  localparam logic [1:0]  SLOT_USR = 2'd0;
  localparam logic [1:0]  SLOT_SUP = 2'd1;
  localparam logic [1:0]  SLOT_INT = 2'd2;
  localparam logic [15:0] SR_KEEP  = 16'hFFE0;
  localparam logic [15:0] SR_RST   = 16'h2000;
  localparam int          S_BIT    = 13;
  localparam int          M_BIT    = 12;
  localparam bit          SPLIT    = (HAS_MASTER != 0) && (ALT_MODE == 0);

  function automatic logic [1:0] pick(input logic [15:0] s, input logic e);
    if (ALT_MODE != 0)       return (s[S_BIT] && e) ? SLOT_SUP : SLOT_USR;
    else if (!s[S_BIT])      return SLOT_USR;
    else if (HAS_MASTER == 0) return SLOT_SUP;
    else                     return s[M_BIT] ? SLOT_SUP : SLOT_INT;
  endfunction

  localparam logic [1:0] RST_SLOT = pick(SR_RST, 1'b0);

  logic [15:0]   sr_r, sr_n;
  logic          eusp_r, eusp_n;
  logic [DW-1:0] a7_r, a7_pre;
  logic [1:0]    cur_q, new_slot;
  logic [DW-1:0] slot_q [3];
  logic          swap, ctl_legal, ctl_wr_ok, ctl_hits_cur;
  logic [DW-1:0] slot_rd;

  assign sr_n      = sr_wr ? (sr_wdata & SR_KEEP) : sr_r;
  assign eusp_n    = cacr_wr ? cacr_eusp : eusp_r;
  assign new_slot  = pick(sr_n, eusp_n);
  assign swap      = sr_wr | cacr_wr;
  assign a7_pre    = a7_wr ? a7_wdata : a7_r;

  assign ctl_legal    = (ctl_sel == SLOT_USR) ||
                        (SPLIT && (ctl_sel == SLOT_SUP || ctl_sel == SLOT_INT));
  assign ctl_illegal  = ctl_req & ~ctl_legal;
  assign ctl_wr_ok    = ctl_req & ctl_write & ctl_legal;
  assign ctl_hits_cur = (ctl_sel == cur_q);

  always_comb begin
    case (ctl_sel)
      SLOT_USR: slot_rd = slot_q[0];
      SLOT_SUP: slot_rd = slot_q[1];
      SLOT_INT: slot_rd = slot_q[2];
      default:  slot_rd = '0;
    endcase
  end

  assign ctl_rdata   = (ctl_req && ctl_legal) ? (ctl_hits_cur ? a7_r : slot_rd) : '0;
  assign sr_q        = sr_r;
  assign a7          = a7_r;
  assign active_slot = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_r   <= SR_RST;
      eusp_r <= 1'b0;
      a7_r   <= '0;
      cur_q  <= RST_SLOT;
      for (int i = 0; i < 3; i++) slot_q[i] <= '0;
    end else begin
      sr_r   <= sr_n;
      eusp_r <= eusp_n;
      if (swap) begin
        slot_q[cur_q] <= a7_pre;
        cur_q         <= new_slot;
        a7_r          <= (new_slot == cur_q) ? a7_pre : slot_q[new_slot];
      end else if (ctl_wr_ok) begin
        slot_q[ctl_sel] <= ctl_wdata;
        if (ctl_hits_cur) a7_r <= ctl_wdata;
        else if (a7_wr)   a7_r <= a7_wdata;
      end else if (a7_wr) begin
        a7_r <= a7_wdata;
      end
    end
  end
endmodule

module sp_bank_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sr_wr,
  input logic          cacr_wr,
  input logic          a7_wr,
  input logic [DW-1:0] a7_wdata,
  input logic [DW-1:0] a7,
  input logic          ctl_req,
  input logic          ctl_write,
  input logic          ctl_illegal,
  input logic [1:0]    cur_q,
  input logic [DW-1:0] slot_q [3]
);
  a_r12_ctl_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_req && (sr_wr || cacr_wr)));

  a_r2_save_outgoing: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr || cacr_wr) |=> slot_q[$past(cur_q)] == $past(a7_wr ? a7_wdata : a7));

  a_r11_a7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr && !cacr_wr && !a7_wr && !(ctl_req && ctl_write)) |=> $stable(a7));

  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_illegal && !sr_wr && !cacr_wr) |=>
      (slot_q[0] == $past(slot_q[0]) && slot_q[1] == $past(slot_q[1]) &&
       slot_q[2] == $past(slot_q[2])));

  a_r1_slot_code: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != 2'd3);
endmodule

bind sp_bank sp_bank_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .cacr_wr(cacr_wr),
  .a7_wr(a7_wr), .a7_wdata(a7_wdata), .a7(a7), .ctl_req(ctl_req),
  .ctl_write(ctl_write), .ctl_illegal(ctl_illegal), .cur_q(cur_q),
  .slot_q(slot_q)
);

// File: tb/sp_bank_tb.sv
module sp_bank_tb;
  logic        clk = 0, rst_n = 0;
  logic        sr_wr = 0, cacr_wr = 0, cacr_eusp = 0, a7_wr = 0;
  logic [15:0] sr_wdata = 0;
  logic [31:0] a7_wdata = 0, ctl_wdata = 0;
  logic        ctl_req = 0, ctl_write = 0;
  logic [1:0]  ctl_sel = 0;

  logic [15:0] sr_o  [3];
  logic [31:0] a7_o  [3];
  logic [31:0] rd_o  [3];
  logic        ill_o [3];
  logic [1:0]  act_o [3];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] ms [3][3];
  logic [31:0] ma7 [3];
  logic [1:0]  mcur [3];
  logic [15:0] msr;
  logic        me;

  always #5 clk = ~clk;

  sp_bank #(.DW(32), .HAS_MASTER(1), .ALT_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_o[0]),
    .cacr_wr(cacr_wr), .cacr_eusp(cacr_eusp), .a7_wr(a7_wr), .a7_wdata(a7_wdata),
    .a7(a7_o[0]), .ctl_req(ctl_req), .ctl_write(ctl_write), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .ctl_rdata(rd_o[0]), .ctl_illegal(ill_o[0]),
    .active_slot(act_o[0]));
  sp_bank #(.DW(32), .HAS_MASTER(0), .ALT_MODE(0)) u_nom (
    .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_o[1]),
    .cacr_wr(cacr_wr), .cacr_eusp(cacr_eusp), .a7_wr(a7_wr), .a7_wdata(a7_wdata),
    .a7(a7_o[1]), .ctl_req(ctl_req), .ctl_write(ctl_write), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .ctl_rdata(rd_o[1]), .ctl_illegal(ill_o[1]),
    .active_slot(act_o[1]));
  sp_bank #(.DW(32), .HAS_MASTER(1), .ALT_MODE(1)) u_alt (
    .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_o[2]),
    .cacr_wr(cacr_wr), .cacr_eusp(cacr_eusp), .a7_wr(a7_wr), .a7_wdata(a7_wdata),
    .a7(a7_o[2]), .ctl_req(ctl_req), .ctl_write(ctl_write), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .ctl_rdata(rd_o[2]), .ctl_illegal(ill_o[2]),
    .active_slot(act_o[2]));

  function automatic logic [1:0] pick(int k, logic [15:0] s, logic e);
    if (k == 2)     return (s[13] && e) ? 2'd1 : 2'd0;
    if (!s[13])     return 2'd0;
    if (k == 1)     return 2'd1;
    return s[12] ? 2'd1 : 2'd2;
  endfunction

  function automatic bit legal(int k, logic [1:0] sel);
    return (sel == 2'd0) || (k == 0 && (sel == 2'd1 || sel == 2'd2));
  endfunction

  task automatic cmp(string req, int k, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d: actual %h expected %h", req, k, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    for (int k = 0; k < 3; k++) begin
      cmp(req, k, a7_o[k], ma7[k]);
      cmp(req, k, {30'd0, act_o[k]}, {30'd0, mcur[k]});
      cmp("R7", k, {16'd0, sr_o[k]}, {16'd0, msr});
    end
    for (int s = 0; s < 4; s++) begin
      ctl_req = 1; ctl_write = 0; ctl_sel = 2'(s);
      #1;
      for (int k = 0; k < 3; k++) begin
        logic [31:0] e;
        e = !legal(k, 2'(s)) ? 32'd0 : (2'(s) == mcur[k]) ? ma7[k] : ms[k][s];
        cmp("R10", k, rd_o[k], e);
        cmp("R8", k, {31'd0, ill_o[k]}, {31'd0, !legal(k, 2'(s))});
      end
    end
    ctl_req = 0;
  endtask

  task automatic swap_step(bit do_sr, bit do_cacr, logic [15:0] w, bit e, bit aw, logic [31:0] av);
    @(negedge clk);
    sr_wr = do_sr; sr_wdata = w; cacr_wr = do_cacr; cacr_eusp = e;
    a7_wr = aw; a7_wdata = av;
    if (do_sr) msr = w & 16'hFFE0;
    if (do_cacr) me = e;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] pre;
      logic [1:0] nw;
      pre = aw ? av : ma7[k];
      ma7[k] = pre;
      if (do_sr || do_cacr) begin
        nw = pick(k, msr, me);
        ms[k][mcur[k]] = pre;
        if (nw != mcur[k]) ma7[k] = ms[k][nw];
        mcur[k] = nw;
      end
    end
    @(posedge clk);
    @(negedge clk);
    sr_wr = 0; cacr_wr = 0; a7_wr = 0;
  endtask

  task automatic ctl_step(logic [1:0] sel, logic [31:0] v, bit aw, logic [31:0] av);
    @(negedge clk);
    ctl_req = 1; ctl_write = 1; ctl_sel = sel; ctl_wdata = v;
    a7_wr = aw; a7_wdata = av;
    #1;
    for (int k = 0; k < 3; k++)
      cmp("R8", k, {31'd0, ill_o[k]}, {31'd0, !legal(k, sel)});
    for (int k = 0; k < 3; k++) begin
      if (aw) ma7[k] = av;
      if (legal(k, sel)) begin
        ms[k][sel] = v;
        if (sel == mcur[k]) ma7[k] = v;
      end
    end
    @(posedge clk);
    @(negedge clk);
    ctl_req = 0; ctl_write = 0; a7_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    msr = 16'h2000; me = 0;
    for (int k = 0; k < 3; k++) begin
      ma7[k] = 0;
      for (int s = 0; s < 3; s++) ms[k][s] = 0;
    end
    mcur[0] = 2'd2; mcur[1] = 2'd1; mcur[2] = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1");

    // R8 R9: preload every slot code; only legal ones land
    for (int s = 0; s < 4; s++) ctl_step(2'(s), 32'h1000_0000 * (s + 1) + 32'h11, 1'b0, 32'd0);
    chk_state("R9");
    ctl_step(2'd0, 32'h0000_0ABC, 1'b1, 32'h0000_0DEF);
    chk_state("R9");

    // R2..R7 R11: sweep S, M, flag, write kind and a simultaneous A7 write
    for (int i = 0; i < 128; i++) begin
      bit s, m, e, use_sr, aw;
      logic [15:0] w;
      s = i[0]; m = i[1]; e = i[2]; aw = i[4];
      use_sr = !i[3] || i[6];
      w = {2'b10, s, m, i[3:0], 8'hFF};
      swap_step(use_sr, i[3], w, e, aw, 32'hA700_0000 + i);
      chk_state(s ? (m ? "R4" : "R5") : (e ? "R6" : "R3"));
      if (i[5]) begin
        ctl_step(2'd0, 32'hC000_0000 + i, 1'b1, 32'hB000_0000 + i);
        chk_state("R9");
      end else begin
        swap_step(1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 32'h5100_0000 + i);
        chk_state("R11");
        swap_step(1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 32'd0);
        chk_state("R11");
      end
    end
    // R2: re-select the same slot with a concurrent A7 write
    swap_step(1'b1, 1'b0, msr, me, 1'b1, 32'h0123_4567);
    chk_state("R2");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule